// File: doc/BRIEF.md
# Event-Selectable Performance Counter Unit

This block holds six 32-bit performance counters for a processor core. Each clock it receives the number of instructions completed in that cycle and a run-latch flag. An event-select register assigns counters 1 to 4 their source: completed instructions, elapsed clock cycles, or nothing. Counter 5 always counts instructions and counter 6 always counts cycles. A set of freeze bits in the main control register stops the counters. One freeze bit covers all six counters, one covers the first four, and one covers the last two.

When a counting counter reaches the negative half of its range and its overflow enable is set, it saturates at exactly 0x8000_0000 and raises an alert. The alert can set the global freeze bit. It can also turn an armed alert-enable bit into a sticky pending bit that drives the interrupt output. Software reaches all registers through a simple address/write port. Reads are combinational.

Top module: `perf_counter_unit`

## Requirements
- R1: Synchronous reset clears every register and counter to zero and drops `pmi_irq`.
- R2: The event field of counter 1 is evsel[31:24], counter 2 is evsel[23:16] and counter 3 is evsel[15:8]. Code 0x02 adds `ins_cnt` each cycle. Code 0x1E adds one each cycle. Any other code holds the counter.
- R3: Counter 4 uses evsel[7:0]. Code 0x02 adds `ins_cnt` whatever `run_latch` is. Code 0xFA adds `ins_cnt` only in cycles where `run_latch` is 1. Code 0x1E adds one per cycle. Other codes hold.
- R4: Counter 5 adds `ins_cnt` and counter 6 adds one every cycle. Both are gated only by control bit 0 (freeze all) and control bit 2 (freeze 5/6).
- R5: Control bit 0 stops all six counters. Counters 1 to 4 advance only when bit 0 and bit 1 (freeze 1–4) are both clear and the whole event-select register is nonzero.
- R6: Control bit 6 enables overflow for counter 1 only. Control bit 7 enables overflow for counters 2 to 6.
- R7: The overflow test is made on a 33-bit sum. If the counter is advancing, its enable is on and the sum is at least 2^31, the counter is loaded with 0x8000_0000 and an alert is raised. This covers instruction and cycle sources and holds even when the sum carries out of 32 bits.
- R8: On an alert, control bit 3 set causes bit 0 to be set. If bit 4 (alert enable) is set, bit 4 is cleared, bit 5 (alert seen) is set and `pmi_irq` rises. All of this takes effect on the same edge as the saturation.
- R9: A write to control register 0 sets `pmi_irq` to bit 5 of the written value. A write to register 1 or 2 sets `pmi_irq` to the current bit 5. Software can therefore raise or clear the interrupt.
- R10: A counter write keeps the low 32 bits of `reg_wdata` and takes priority over counting in that cycle. Counting in any cycle uses the control values held before that cycle's write.
- R11: The address map is 0 control, 1 event select, 2 spare control (plain storage) and 3 to 8 counters 1 to 6. `reg_rdata` follows `reg_addr` combinationally, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_cnt | input | 3 | Instructions completed this cycle |
| run_latch | input | 1 | Run-latch state, gates event 0xFA on counter 4 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data; only the low 32 bits are kept |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pmi_irq | output | 1 | Performance-monitor interrupt |

## Verification
The hardest condition to reach from the ports is an overflow whose 33-bit sum carries out. A plain 32-bit add would wrap to a small value and miss the overflow. The bench loads counter 6 with 0xFFFF_FFFF under freeze, then releases it with overflow enabled. One cycle later it expects the saturated boundary and a raised alert. Interactions between the freeze bits and the event codes come from a sweep over every freeze combination, five codes and both run-latch levels, with the expected totals computed as sums of the applied increments.

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int CW  = 32,
  parameter int IW  = 3,
  parameter int WDW = 64,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  ins_cnt,
  input  logic           run_latch,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [WDW-1:0] reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           pmi_irq
);
  localparam int RW = 32;
  localparam int NC = 6;
  localparam logic [CW-1:0] BOUND = {1'b1, {(CW-1){1'b0}}};
  localparam int FA = 0, F14 = 1, F56 = 2, FRZ = 3, AEN = 4, ASEEN = 5, OE1 = 6, OEJ = 7;
  localparam logic [7:0] EV_INS = 8'h02, EV_CYC = 8'h1E, EV_RUN = 8'hFA;

  logic [RW-1:0] ctl, evsel, aux;
  logic [CW-1:0] cnt [NC];
  logic [CW-1:0] nxt [NC];
  logic [NC-1:0] use_ins, use_cyc, hit;
  logic          irq_q;

  wire unused_hi = ^reg_wdata[WDW-1:RW];
  wire grp14 = !ctl[FA] && !ctl[F14] && (evsel != '0);
  wire grp56 = !ctl[FA] && !ctl[F56];
  wire alert = |hit;
  wire raise = alert && ctl[AEN];
  wire ctl_wr = reg_wr && reg_addr == AW'(0);
  wire cfg_wr = reg_wr && (reg_addr == AW'(1) || reg_addr == AW'(2));

  always_comb begin
    use_ins = '0;
    use_cyc = '0;
    for (int i = 0; i < 4; i++) begin
      use_ins[i] = grp14 && evsel[31-8*i -: 8] == EV_INS;
      use_cyc[i] = grp14 && evsel[31-8*i -: 8] == EV_CYC;
    end
    use_ins[3] = use_ins[3] || (grp14 && run_latch && evsel[7:0] == EV_RUN);
    use_ins[4] = grp56;
    use_cyc[5] = grp56;
  end

  for (genvar k = 0; k < NC; k++) begin : g_cnt
    logic [CW:0] sum;
    wire oe = (k == 0) ? ctl[OE1] : ctl[OEJ];
    assign sum = {1'b0, cnt[k]} + (use_ins[k] ? (CW+1)'(ins_cnt) : (CW+1)'(use_cyc[k]));
    assign hit[k] = (use_ins[k] || use_cyc[k]) && oe && (sum[CW] || sum[CW-1]);
    assign nxt[k] = hit[k] ? BOUND : sum[CW-1:0];

    always_ff @(posedge clk) begin
      if (rst) cnt[k] <= '0;
      else if (reg_wr && reg_addr == AW'(3 + k)) cnt[k] <= reg_wdata[CW-1:0];
      else if (use_ins[k] || use_cyc[k]) cnt[k] <= nxt[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      evsel <= '0;
      aux   <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= reg_wdata[RW-1:0];
      else if (alert) begin
        if (ctl[FRZ]) ctl[FA] <= 1'b1;
        if (ctl[AEN]) begin
          ctl[AEN]   <= 1'b0;
          ctl[ASEEN] <= 1'b1;
        end
      end
      if (reg_wr && reg_addr == AW'(1)) evsel <= reg_wdata[RW-1:0];
      if (reg_wr && reg_addr == AW'(2)) aux <= reg_wdata[RW-1:0];
      if (ctl_wr) irq_q <= reg_wdata[ASEEN];
      else        irq_q <= (cfg_wr ? ctl[ASEEN] : irq_q) || raise;
    end
  end

  assign pmi_irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata = ctl;
      AW'(1): reg_rdata = evsel;
      AW'(2): reg_rdata = aux;
      default:
        for (int k = 0; k < NC; k++)
          if (reg_addr == AW'(3 + k)) reg_rdata = RW'(cnt[k]);
    endcase
  end

  // R5
  freeze_all_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl[FA] && !reg_wr) |=> ($stable(cnt[0]) && $stable(cnt[1]) && $stable(cnt[2]) &&
                              $stable(cnt[3]) && $stable(cnt[4]) && $stable(cnt[5])));
  // R7
  clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (use_ins[4] && ctl[OEJ] && !(reg_wr && reg_addr == AW'(7))) |=> (cnt[4] <= BOUND));
  // R8
  alert_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (raise && !reg_wr) |=> (ctl[ASEEN] && !ctl[AEN] && pmi_irq));
  // R8
  freeze_on_alert_chk: assert property (@(posedge clk) disable iff (rst)
    (alert && ctl[FRZ] && !reg_wr) |=> ctl[FA]);
  // R9
  irq_wr_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (pmi_irq == $past(reg_wdata[ASEEN])));
endmodule

// File: tb/tb_perf_counter_unit.sv
`timescale 1ns/100ps
module tb_perf_counter_unit;
  localparam real CLK_P = 10.0;
  logic clk = 1'b0, rst = 1'b1, run_latch = 1'b0, reg_wr = 1'b0;
  logic [2:0] ins_cnt = '0;
  logic [3:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pmi_irq;
  int total = 0, bad = 0;
  bit done = 0;

  perf_counter_unit dut (.clk, .rst, .ins_cnt, .run_latch, .reg_wr, .reg_addr,
                         .reg_wdata, .reg_rdata, .pmi_irq);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a; #0.5; v = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; ins_cnt = 3'd3;
    @(negedge clk);
    reg_wr = 1'b0; ins_cnt = '0;
  endtask

  task automatic tick(input logic [2:0] n);
    ins_cnt = n;
    @(negedge clk);
    ins_cnt = '0;
  endtask

  task automatic setup(input logic [31:0] ev, input logic [31:0] c0, input logic [31:0] c5v,
                       input logic [31:0] c6v, input logic [31:0] cfg);
    wr(0, 64'h1);
    wr(1, {32'h0, ev});
    wr(3, {32'h0, c0});
    for (int k = 1; k < 4; k++) wr(4'(3 + k), 64'h0);
    wr(7, {32'h0, c5v});
    wr(8, {32'h0, c6v});
    wr(0, {32'h0, cfg});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] codes [5];
    codes[0] = 8'h00; codes[1] = 8'h02; codes[2] = 8'h1E; codes[3] = 8'hFA; codes[4] = 8'h77;
    @(negedge clk); @(negedge clk);
    for (int a = 0; a < 9; a++) begin rd(4'(a), v); chk("R1 reset reg", v, 32'h0); end
    chk("R1 reset irq", 32'(pmi_irq), 32'h0);
    rst = 1'b0;

    // R2 R3 R4 R5 sweep
    for (int fr = 0; fr < 8; fr++)
      for (int ci = 0; ci < 5; ci++)
        for (int rl = 0; rl < 2; rl++) begin
          logic [7:0] c;
          logic [31:0] e14, e4, e5, e6;
          bit g14, g56;
          c = codes[ci];
          setup({c, c, c, c}, 0, 0, 0, 32'(fr));
          run_latch = rl[0];
          for (int s = 1; s <= 4; s++) tick(3'(s));
          g14 = !fr[0] && !fr[1] && c != 8'h00;
          g56 = !fr[0] && !fr[2];
          e14 = !g14 ? 0 : (c == 8'h02) ? 10 : (c == 8'h1E) ? 4 : 0;
          e4  = !g14 ? 0 : (c == 8'h02 || (c == 8'hFA && rl == 1)) ? 10 : (c == 8'h1E) ? 4 : 0;
          e5  = g56 ? 10 : 0;
          e6  = g56 ? 4 : 0;
          for (int k = 0; k < 3; k++) begin rd(4'(3 + k), v); chk("R2 R5 counter1-3", v, e14); end
          rd(6, v); chk("R3 R5 counter4", v, e4);
          rd(7, v); chk("R4 counter5", v, e5);
          rd(8, v); chk("R4 counter6", v, e6);
        end

    // R2 distinct byte positions
    setup(32'h021E_00FA, 0, 0, 0, 32'h4);
    run_latch = 1'b1; tick(2); run_latch = 1'b0; tick(5); run_latch = 1'b1; tick(1);
    rd(3, v); chk("R2 counter1 ins", v, 8);
    rd(4, v); chk("R2 counter2 cyc", v, 3);
    rd(5, v); chk("R2 counter3 hold", v, 0);
    rd(6, v); chk("R3 counter4 run-gated", v, 3);

    // R7 R8 R6: counter1 overflow with freeze and alert enable
    setup(32'h0200_0000, 32'h7FFF_FFFE, 0, 0, 32'h5C);
    tick(5);
    rd(3, v); chk("R7 counter1 clamp", v, 32'h8000_0000);
    rd(0, v); chk("R8 ctl after alert", v, 32'h6D);
    chk("R8 irq raised", 32'(pmi_irq), 1);
    tick(3);
    rd(3, v); chk("R8 frozen after alert", v, 32'h8000_0000);
    wr(0, 64'h1);
    chk("R9 ctl write clears irq", 32'(pmi_irq), 0);

    // R6: counter1 ignores the shared enable
    setup(32'h0200_0000, 32'h7FFF_FFFE, 0, 0, 32'h94);
    tick(5);
    rd(3, v); chk("R6 counter1 no clamp", v, 32'h8000_0003);
    rd(0, v); chk("R6 ctl unchanged", v, 32'h94);
    chk("R6 no irq", 32'(pmi_irq), 0);

    // R7 cycle counter with carry-out, no freeze
    setup(32'h0, 0, 0, 32'hFFFF_FFFF, 32'h90);
    tick(2);
    rd(8, v); chk("R7 counter6 carry clamp", v, 32'h8000_0000);
    rd(0, v); chk("R8 ctl no freeze", v, 32'hA0);
    chk("R8 irq", 32'(pmi_irq), 1);
    tick(3);
    rd(7, v); chk("R4 counter5 keeps going", v, 5);
    rd(8, v); chk("R7 counter6 reclamp", v, 32'h8000_0000);

    // R9 software raise / clear, and via register 1
    wr(0, 64'h1);
    chk("R9 clear", 32'(pmi_irq), 0);
    wr(0, 64'hFFFF_FFFF_0000_0021);
    chk("R9 raise", 32'(pmi_irq), 1);
    rd(0, v); chk("R10 ctl low bits", v, 32'h21);
    wr(0, 64'h1);
    wr(1, 64'h0);
    chk("R9 evsel write with seen clear", 32'(pmi_irq), 0);

    // R10 truncation and write priority
    wr(0, 64'h0);
    wr(7, 64'hABCD_0000_1234_5678);
    rd(7, v); chk("R10 write wins and truncates", v, 32'h1234_5678);
    tick(7);
    rd(7, v); chk("R10 counting resumes", v, 32'h1234_567F);

    // R11 map
    wr(0, 64'h1);
    wr(2, 64'hFFFF_FFFF_DEAD_BEEF);
    rd(2, v); chk("R11 spare reg", v, 32'hDEAD_BEEF);
    for (int a = 9; a < 16; a++) begin rd(4'(a), v); chk("R11 unmapped", v, 32'h0); end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule